// File: doc/BRIEF.md
# Burst Address Sequencer

This block supplies the address for each beat of a four-beat burst. A burst opens with a one-cycle start pulse that captures a full address. The upper bits of that address are then held for the whole burst. The lowest two bits follow a sequence that starts from the captured value. An active-low step strobe moves the burst forward by one beat at each rising clock edge. While the strobe is high, the burst is suspended. Read and write bursts both take their addresses from this one sequencer.

A static order input chooses between two sequences. In linear order the two low bits count upward modulo four from the start value. In interleaved order each beat's low bits are the start value XORed with the beat number. The block also reports the beat index, which runs 0 to 3.

Control is a two-state machine:
- `ST_IDLE` is the state after reset. No burst has been opened yet, and step strobes are ignored.
- Transition IDLE→BURST is taken on a start pulse.
- BURST→BURST on a start pulse (restart) reloads the address and clears the beat.
- BURST→BURST on a step strobe advances the beat.
- BURST→BURST with neither input active holds the beat.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset `addr_o` is all zeros and `beat_o` is 0.
- R2: In the cycle after a clock edge that samples `start_i` high, `beat_o` is 0 and `addr_o` equals the sampled `addr_i`, in either order.
- R3: With `order_i` = 0 (linear), the low two bits of `addr_o` equal (start + `beat_o`) modulo 4, e.g. start 01 gives 01,10,11,00.
- R4: With `order_i` = 1 (interleaved), the low two bits of `addr_o` equal start XOR `beat_o`, e.g. start 10 gives 10,11,00,01 and start 11 gives 11,10,01,00.
- R5: During a burst, a clock edge that samples `step_n_i` low and `start_i` low increments `beat_o` by one, modulo 4.
- R6: During a burst, a clock edge that samples `step_n_i` high and `start_i` low leaves `beat_o` and `addr_o` unchanged.
- R7: When `start_i` and a low `step_n_i` are sampled at the same edge, the start wins: `beat_o` becomes 0 and the new address is loaded.
- R8: A step taken at beat 3 returns `beat_o` to 0, and the low bits of `addr_o` return to the start value.
- R9: Bits above bit 1 of `addr_o` keep the value captured at the start for the whole burst.
- R10: Before the first start pulse after reset, step strobes have no effect: `beat_o` stays 0 and `addr_o` stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Burst start pulse; captures `addr_i` |
| step_n_i | input | 1 | Active-low advance strobe |
| order_i | input | 1 | Static order select: 0 linear, 1 interleaved |
| addr_i | input | ADDR_W | Start address |
| addr_o | output | ADDR_W | Current beat address |
| beat_o | output | 2 | Beat index 0..3 |

## Verification
Every result is registered once. Beat index, captured upper bits and start value all change at the clock edge that samples the stimulus, so each result is due one cycle after that stimulus. The address output is formed combinationally from those registers and the order input, so it settles within the same cycle. The bench drives inputs on the falling edge, lets exactly one rising edge pass, and compares on the following falling edge. A check therefore always sees the result of precisely the one edge it is aimed at. Expected addresses come from a separate model of the two orders, applied to the start value and a beat count kept by the bench.

// File: rtl/burst_pkg.sv
package burst_pkg;
    localparam int LOW_W  = 2;
    localparam int BEATS  = 1 << LOW_W;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } burst_state_e;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;
endpackage

// File: rtl/burst_ctrl_fsm.sv
module burst_ctrl_fsm
    import burst_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         step_n_i,
    output burst_state_e state_o,
    output logic         capture_o,
    output logic         advance_o
);
    burst_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_BURST;
            ST_BURST: state_d = ST_BURST;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs: start has priority over step
    always_comb begin
        capture_o = start_i;
        advance_o = 1'b0;
        unique case (state_q)
            ST_IDLE:  advance_o = 1'b0;
            ST_BURST: advance_o = !start_i && !step_n_i;
            default:  advance_o = 1'b0;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/burst_beat_cnt.sv
module burst_beat_cnt
    import burst_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             inc_i,
    output logic [LOW_W-1:0] beat_o
);
    logic [LOW_W-1:0] beat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       beat_q <= '0;
        else if (clear_i) beat_q <= '0;
        else if (inc_i)   beat_q <= beat_q + LOW_W'(1);
    end

    assign beat_o = beat_q;
endmodule

// File: rtl/burst_seq_map.sv
module burst_seq_map
    import burst_pkg::*;
(
    input  logic             order_i,
    input  logic [LOW_W-1:0] start_i,
    input  logic [LOW_W-1:0] beat_i,
    output logic [LOW_W-1:0] low_o
);
    logic [LOW_W-1:0] lin_w;
    logic [LOW_W-1:0] ilv_w;

    // per-bit XOR for the interleaved order
    for (genvar b = 0; b < LOW_W; b++) begin : g_ilv
        assign ilv_w[b] = start_i[b] ^ beat_i[b];
    end

    assign lin_w = start_i + beat_i;

    always_comb begin
        unique case (burst_order_e'(order_i))
            ORD_LINEAR:     low_o = lin_w;
            ORD_INTERLEAVE: low_o = ilv_w;
            default:        low_o = lin_w;
        endcase
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              step_n_i,
    input  logic              order_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [LOW_W-1:0]  beat_o
);
    localparam int UP_W = ADDR_W - LOW_W;

    burst_state_e     state_q;
    logic             capture_w;
    logic             advance_w;
    logic [UP_W-1:0]  upper_q;
    logic [LOW_W-1:0] start_q;
    logic [LOW_W-1:0] beat_w;
    logic [LOW_W-1:0] low_w;

    burst_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .step_n_i  (step_n_i),
        .state_o   (state_q),
        .capture_o (capture_w),
        .advance_o (advance_w)
    );

    burst_beat_cnt u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (capture_w),
        .inc_i   (advance_w),
        .beat_o  (beat_w)
    );

    // captured start address
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upper_q <= '0;
            start_q <= '0;
        end else if (capture_w) begin
            upper_q <= addr_i[ADDR_W-1:LOW_W];
            start_q <= addr_i[LOW_W-1:0];
        end
    end

    burst_seq_map u_map (
        .order_i (order_i),
        .start_i (start_q),
        .beat_i  (beat_w),
        .low_o   (low_w)
    );

    assign addr_o = {upper_q, low_w};
    assign beat_o = beat_w;
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk
    import burst_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              step_n_i,
    input logic              order_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [ADDR_W-1:0] addr_o,
    input logic [LOW_W-1:0]  beat_o,
    input burst_state_e      state_q
);
    // R2 R7
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (beat_o == '0 && addr_o == $past(addr_i)));

    // R5
    step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BURST && !start_i && !step_n_i) |=> beat_o == $past(beat_o) + LOW_W'(1));

    // R6
    suspend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BURST && !start_i && step_n_i) |=> ($stable(beat_o) && (!$stable(order_i) || $stable(addr_o))));

    // R9
    upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(addr_o[ADDR_W-1:LOW_W]));

    // R3
    linear_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BURST && !start_i && !step_n_i && order_i == 1'b0)
        |=> (order_i != 1'b0 || addr_o[LOW_W-1:0] == $past(addr_o[LOW_W-1:0]) + LOW_W'(1)));

    // R4
    interleave_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BURST && !start_i && order_i == 1'b1)
        |=> (order_i != 1'b1 || (addr_o[LOW_W-1:0] ^ beat_o) == $past(addr_o[LOW_W-1:0] ^ beat_o)));

    // R10
    idle_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start_i) |=> (beat_o == '0 && addr_o == '0));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .step_n_i (step_n_i),
    .order_i  (order_i),
    .addr_i   (addr_i),
    .addr_o   (addr_o),
    .beat_o   (beat_o),
    .state_q  (state_q)
);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 20;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              start_i;
    logic              step_n_i;
    logic              order_i;
    logic [ADDR_W-1:0] addr_i;
    logic [ADDR_W-1:0] addr_o;
    logic [1:0]        beat_o;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_addr_gen #(.ADDR_W(ADDR_W)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .step_n_i (step_n_i),
        .order_i  (order_i),
        .addr_i   (addr_i),
        .addr_o   (addr_o),
        .beat_o   (beat_o)
    );

    function automatic logic [1:0] model_low(logic ord, logic [1:0] s, logic [1:0] b);
        return ord ? (s ^ b) : 2'((s + b) & 2'b11);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at falling edge, pass one rising edge, return at next falling edge
    task automatic cyc(logic st, logic stp_n, logic [ADDR_W-1:0] a);
        start_i  = st;
        step_n_i = stp_n;
        addr_i   = a;
        @(negedge clk);
    endtask

    task automatic check_beat(string req, logic ord, logic [ADDR_W-1:0] base, logic [1:0] b);
        check(req, 32'(beat_o), 32'(b));
        check(req, 32'(addr_o), 32'({base[ADDR_W-1:2], model_low(ord, base[1:0], b)}));
    endtask

    task automatic t_reset();
        check("R1", 32'(addr_o), 32'd0);
        check("R1", 32'(beat_o), 32'd0);
        // R10: steps before any start are ignored
        cyc(1'b0, 1'b0, 20'hFFFFF);
        cyc(1'b0, 1'b0, 20'h12345);
        check("R10", 32'(beat_o), 32'd0);
        check("R10", 32'(addr_o), 32'd0);
    endtask

    task automatic t_burst(logic ord, logic [ADDR_W-1:0] base, string req);
        order_i = ord;
        cyc(1'b1, 1'b1, base);
        check_beat("R2", ord, base, 2'd0);
        for (int k = 1; k <= 4; k++) begin
            cyc(1'b0, 1'b0, ~base);
            check_beat(k == 4 ? "R8" : req, ord, base, 2'(k));
            check("R9", 32'(addr_o[ADDR_W-1:2]), 32'(base[ADDR_W-1:2]));
        end
        check("R8", 32'(addr_o[1:0]), 32'(base[1:0]));
    endtask

    task automatic t_suspend();
        logic [ADDR_W-1:0] base = 20'h5A5A6;
        order_i = 1'b1;
        cyc(1'b1, 1'b1, base);
        cyc(1'b0, 1'b0, '0);
        cyc(1'b0, 1'b1, '0);
        cyc(1'b0, 1'b1, 20'h00003);
        check_beat("R6", 1'b1, base, 2'd1);
        cyc(1'b0, 1'b0, '0);
        check_beat("R5", 1'b1, base, 2'd2);
    endtask

    task automatic t_priority();
        logic [ADDR_W-1:0] a = 20'h0F0F1;
        logic [ADDR_W-1:0] b = 20'hE1E13;
        order_i = 1'b0;
        cyc(1'b1, 1'b1, a);
        cyc(1'b0, 1'b0, '0);
        cyc(1'b0, 1'b0, '0);
        check_beat("R5", 1'b0, a, 2'd2);
        cyc(1'b1, 1'b0, b);
        check_beat("R7", 1'b0, b, 2'd0);
        cyc(1'b0, 1'b0, '0);
        check_beat("R3", 1'b0, b, 2'd1);
    endtask

    initial begin
        rst_n    = 1'b0;
        start_i  = 1'b0;
        step_n_i = 1'b1;
        order_i  = 1'b0;
        addr_i   = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_burst(1'b0, 20'hABCD1, "R3");
        t_burst(1'b0, 20'h00003, "R3");
        t_burst(1'b1, 20'h3C3C2, "R4");
        t_burst(1'b1, 20'hFFFFF, "R4");
        t_suspend();
        t_priority();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule